// File: doc/BRIEF.md
# Four-Channel DMA Register Interface

This block is the byte-wide programming interface of a four-channel DMA engine. A host reaches sixteen byte ports through a small synchronous bus with address, write data, read data, a write strobe and a read strobe. Eight of the ports hold the 16-bit start address and start count of each channel. The other eight are controller-wide: command, request, masking, mode, byte-pointer clear and master reset. The per-channel mode bytes, mask bits and software request bits are driven straight out to the transfer engine.

Each 16-bit channel register sits behind a single 8-bit port. One shared byte pointer picks the low or the high half. Completing the high half restarts that channel: its running address is reloaded from the start value and its progress count returns to zero. The transfer engine reports each completed unit on `step` and each terminal count on `tc_in`. Readback of a channel therefore reflects the live transfer position, not the programmed value. The parameter `WORD_ADDR` picks a byte controller (0) or a word controller (1). In word mode the port index is taken one address bit higher and addresses and counts are kept scaled by two.

Top module: `dma_regif`

## Requirements
- R1: The port index is `(bus_addr >> S) & 0xF` with S = `WORD_ADDR`. Indices 0..7 reach channel registers: channel = index >> 1, an even index selects the address register and an odd index selects the count register.
- R2: One byte pointer, cleared by reset, selects the low byte (0) or the high byte (1) for every channel-register access. It inverts after each channel read or write.
- R3: A low-byte write replaces bits [7:0] of the start register and keeps [15:8]. A high-byte write replaces [15:8] and keeps [7:0].
- R4: A high-byte write to either register of a channel loads that channel's running address with its start address << S and clears its progress. Otherwise a pulse on `step[ch]` adds 1 << S to the progress. A low-byte write reloads nothing.
- R5: An address read yields running address + progress, or running address − progress when mode bit 5 is set. A count read yields (start count << S) − progress. The byte returned is bits [S+8·p +: 8], where p is the pointer, and it is on `bus_rdata` in the cycle after the read strobe.
- R6: A write to index 9 takes data[1:0] as the channel. With data bit 2 = 1 it sets that channel's request bit. With bit 2 = 0 it clears both the request bit and the terminal-count bit of that channel. Request bits drive `chan_req`.
- R7: Mask bits are all ones after reset. Index 10 sets bit data[1:0] when data bit 2 is 1 and clears it otherwise. Index 14 clears all four bits. Index 15 loads data[3:0]. A read of index 9 returns {4'b0, mask}.
- R8: A write to index 11 stores the whole byte as the mode of channel data[1:0], shown on `chan_mode[8*ch +: 8]`.
- R9: A write to index 12 clears the byte pointer. A write to index 13 sets all mask bits and clears the command, request bits, terminal-count bits and pointer. Start registers and modes are kept.
- R10: A write to index 8 stores the command byte when the byte is 0x00 or 0x04. A byte with any other bit set is discarded and the command keeps its value.
- R11: `err_pulse` is high for one cycle, the cycle after a discarded command write or after a read of a write-only index (10..15). Such a read returns 0x00.
- R12: A pulse on `tc_in[ch]` sets terminal-count bit ch. A read of index 8 returns {request[3:0], terminal-count[3:0]} and clears the terminal-count bits, except those set by `tc_in` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4+WORD_ADDR | Port address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| err_pulse | output | 1 | Unsupported command or write-only port read |
| step | input | 4 | Per-channel transfer unit completed |
| tc_in | input | 4 | Per-channel terminal count reached |
| chan_mode | output | 32 | Mode byte of each channel |
| chan_mask | output | 4 | Mask bit of each channel |
| chan_req | output | 4 | Software request bit of each channel |
| ctl_cmd | output | 8 | Accepted command byte |

## Verification
Read data appears one cycle after the read strobe, registered at the strobe's rising edge. The bench monitor notes the strobe at the rising edge and compares `bus_rdata` with the queued expected byte at the following falling edge. Mask, request, mode and command outputs change at the rising edge that accepts a write, so they are checked at the falling edge that ends the write task. `err_pulse` is checked at that same falling edge and again one cycle later to confirm it lasts one cycle. Each transfer-engine pulse lasts exactly one cycle, so the bench can work out the expected progress by counting pulses.

// File: rtl/dma_regif_pkg.sv
// Shared constants for the DMA register interface.
// Assumes four channels and 16-bit start registers reached one byte at a time.
package dma_regif_pkg;

    localparam int NCH = 4;
    localparam int REG_W = 16;

    // Controller-wide port codes: low three bits of indices 8..15
    typedef enum logic [2:0] {
        CP_CMD     = 3'd0,
        CP_REQ     = 3'd1,
        CP_SMASK   = 3'd2,
        CP_MODE    = 3'd3,
        CP_CLRPTR  = 3'd4,
        CP_MRST    = 3'd5,
        CP_CLRMASK = 3'd6,
        CP_LDMASK  = 3'd7
    } ctl_port_e;

    // The only command bit this controller accepts
    localparam logic [7:0] CMD_ACCEPT = 8'h04;

endpackage

// File: rtl/dma_chan_regs.sv
// One DMA channel: start address and count, running address, progress, mode.
// Assumes at most one of addr_we / cnt_we per cycle; hi_sel is the shared
// byte pointer sampled before it toggles.
module dma_chan_regs
    import dma_regif_pkg::*;
#(
    parameter int SHIFT = 0,
    localparam int VW = REG_W + SHIFT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_we,
    input  logic          cnt_we,
    input  logic          hi_sel,
    input  logic [7:0]    wdata,
    input  logic          mode_we,
    input  logic          step,
    output logic [7:0]    mode_q,
    output logic [VW-1:0] addr_val,
    output logic [VW-1:0] cnt_val
);

    logic [REG_W-1:0] base_a, base_c, nxt_a, nxt_c;
    logic [VW-1:0]    cur_a, prog;
    logic             reload;

    assign reload = (addr_we || cnt_we) && hi_sel;

    // Merge the written byte into the selected start register
    always_comb begin
        nxt_a = base_a;
        nxt_c = base_c;
        if (addr_we) nxt_a = hi_sel ? {wdata, base_a[7:0]} : {base_a[15:8], wdata};
        if (cnt_we)  nxt_c = hi_sel ? {wdata, base_c[7:0]} : {base_c[15:8], wdata};
    end

    // Hold the start registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_a <= '0;
            base_c <= '0;
        end else begin
            base_a <= nxt_a;
            base_c <= nxt_c;
        end
    end

    // Reload running address on a high-byte write, else advance progress
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_a <= '0;
            prog  <= '0;
        end else if (reload) begin
            cur_a <= VW'(nxt_a) << SHIFT;
            prog  <= '0;
        end else if (step) begin
            prog  <= prog + VW'(1 << SHIFT);
        end
    end

    // Hold the mode byte
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_we) mode_q <= wdata;
    end

    assign addr_val = mode_q[5] ? (cur_a - prog) : (cur_a + prog);
    assign cnt_val  = (VW'(base_c) << SHIFT) - prog;

    AST_RELOAD_CLEARS_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt_val == (VW'($past(nxt_c)) << SHIFT))); // R4

endmodule

// File: rtl/dma_ctl_regs.sv
// Controller-wide state: command, mask, request, terminal count, byte
// pointer and error pulse. Assumes wr_i and the read inputs never coincide.
module dma_ctl_regs
    import dma_regif_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_i,
    input  logic [2:0]     port,
    input  logic [7:0]     wdata,
    input  logic           rd_status,
    input  logic           rd_wo,
    input  logic           chan_acc,
    input  logic [NCH-1:0] tc_in,
    output logic [7:0]     cmd_q,
    output logic [NCH-1:0] mask_q,
    output logic [NCH-1:0] req_q,
    output logic [NCH-1:0] tc_q,
    output logic           ptr_q,
    output logic           err_q
);

    logic           wr_cmd, cmd_bad, mrst, clr_ptr;
    logic [NCH-1:0] mask_n, req_n, tc_n, sel1h;

    assign wr_cmd  = wr_i && (port == CP_CMD);
    assign cmd_bad = wr_cmd && ((wdata & ~CMD_ACCEPT) != 8'h00);
    assign mrst    = wr_i && (port == CP_MRST);
    assign clr_ptr = wr_i && (port == CP_CLRPTR);
    assign sel1h   = NCH'(1) << wdata[1:0];

    // Next mask, request and terminal-count values from port writes
    always_comb begin
        mask_n = mask_q;
        req_n  = req_q;
        tc_n   = tc_q;
        if (rd_status) tc_n = '0;
        if (wr_i) begin
            case (ctl_port_e'(port))
                CP_SMASK:   mask_n = wdata[2] ? (mask_q | sel1h) : (mask_q & ~sel1h);
                CP_CLRMASK: mask_n = '0;
                CP_LDMASK:  mask_n = wdata[NCH-1:0];
                CP_REQ: begin
                    if (wdata[2]) req_n = req_q | sel1h;
                    else begin
                        req_n = req_q & ~sel1h;
                        tc_n  = tc_q & ~sel1h;
                    end
                end
                default: ;
            endcase
        end
        tc_n = tc_n | tc_in;
    end

    // Register controller state; master reset overrides port effects
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            mask_q <= '1;
            req_q  <= '0;
            tc_q   <= '0;
            ptr_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            err_q <= cmd_bad || rd_wo;
            if (mrst) begin
                cmd_q  <= '0;
                mask_q <= '1;
                req_q  <= '0;
                tc_q   <= '0;
                ptr_q  <= 1'b0;
            end else begin
                if (wr_cmd && !cmd_bad) cmd_q <= wdata;
                mask_q <= mask_n;
                req_q  <= req_n;
                tc_q   <= tc_n;
                if (clr_ptr)       ptr_q <= 1'b0;
                else if (chan_acc) ptr_q <= ~ptr_q;
            end
        end
    end

    AST_PTR_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        chan_acc |=> (ptr_q != $past(ptr_q))); // R2
    AST_MRST_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        mrst |=> (mask_q == '1 && req_q == '0 && cmd_q == '0 && !ptr_q)); // R9
    AST_BAD_CMD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_bad |=> ($stable(cmd_q) && err_q)); // R10
    AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && tc_in == '0) |=> (tc_q == '0)); // R12

endmodule

// File: rtl/dma_regif.sv
// Byte-wide register interface of a four-channel DMA controller.
// Decodes the port index, routes writes to channel or controller state and
// registers the read byte. Assumes bus_wr and bus_rd are single-cycle
// strobes; a write wins if both are raised together.
module dma_regif
    import dma_regif_pkg::*;
#(
    parameter int WORD_ADDR = 0,
    localparam int SHIFT = (WORD_ADDR != 0) ? 1 : 0,
    localparam int AW = 4 + SHIFT,
    localparam int VW = REG_W + SHIFT
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [7:0]     bus_wdata,
    output logic [7:0]     bus_rdata,
    output logic           err_pulse,
    input  logic [NCH-1:0] step,
    input  logic [NCH-1:0] tc_in,
    output logic [8*NCH-1:0] chan_mode,
    output logic [NCH-1:0] chan_mask,
    output logic [NCH-1:0] chan_req,
    output logic [7:0]     ctl_cmd
);

    logic [3:0]     idx;
    logic [1:0]     chan;
    logic           is_chan, rd_go, wr_ch, rd_ch, wr_ctl;
    logic           rd_status, rd_mask, rd_wo;
    logic           ptr_q;
    logic [NCH-1:0] mode_we, tc_q;
    logic [VW-1:0]  addr_val [NCH];
    logic [VW-1:0]  cnt_val  [NCH];
    logic [VW-1:0]  sel_val;
    logic [7:0]     rd_byte;

    assign idx       = bus_addr[SHIFT +: 4];
    assign chan      = idx[2:1];
    assign is_chan   = !idx[3];
    assign rd_go     = bus_rd && !bus_wr;
    assign wr_ch     = bus_wr && is_chan;
    assign rd_ch     = rd_go && is_chan;
    assign wr_ctl    = bus_wr && !is_chan;
    assign rd_status = rd_go && (idx == 4'd8);
    assign rd_mask   = rd_go && (idx == 4'd9);
    assign rd_wo     = rd_go && (idx >= 4'd10);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign mode_we[g] = wr_ctl && (idx[2:0] == CP_MODE) && (bus_wdata[1:0] == 2'(g));
        dma_chan_regs #(.SHIFT(SHIFT)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .addr_we  (wr_ch && chan == 2'(g) && !idx[0]),
            .cnt_we   (wr_ch && chan == 2'(g) && idx[0]),
            .hi_sel   (ptr_q),
            .wdata    (bus_wdata),
            .mode_we  (mode_we[g]),
            .step     (step[g]),
            .mode_q   (chan_mode[8*g +: 8]),
            .addr_val (addr_val[g]),
            .cnt_val  (cnt_val[g])
        );
    end

    dma_ctl_regs u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_ctl),
        .port      (idx[2:0]),
        .wdata     (bus_wdata),
        .rd_status (rd_status),
        .rd_wo     (rd_wo),
        .chan_acc  (wr_ch || rd_ch),
        .tc_in     (tc_in),
        .cmd_q     (ctl_cmd),
        .mask_q    (chan_mask),
        .req_q     (chan_req),
        .tc_q      (tc_q),
        .ptr_q     (ptr_q),
        .err_q     (err_pulse)
    );

    // Select the readback byte for the addressed port
    always_comb begin
        sel_val = idx[0] ? cnt_val[chan] : addr_val[chan];
        if (is_chan)      rd_byte = ptr_q ? sel_val[SHIFT+8 +: 8] : sel_val[SHIFT +: 8];
        else if (rd_status) rd_byte = {chan_req, tc_q};
        else if (rd_mask) rd_byte = {4'h0, chan_mask};
        else              rd_byte = 8'h00;
    end

    // Register read data on each read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)     bus_rdata <= 8'h00;
        else if (rd_go) bus_rdata <= rd_byte;
    end

    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_wo |=> (bus_rdata == 8'h00 && err_pulse)); // R11

endmodule

// File: tb/dma_regif_test.sv
// Scoreboard bench: read tasks queue expected bytes, a monitor compares them.
module dma_regif_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        err_pulse;
    logic [3:0]  step = '0, tc_in = '0;
    logic [31:0] chan_mode;
    logic [3:0]  chan_mask, chan_req;
    logic [7:0]  ctl_cmd;

    int n_run = 0, n_fail = 0;
    int    exp_q[$];
    string tag_q[$];
    logic  pend = 1'b0;

    always #4 clk = ~clk;

    dma_regif uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .err_pulse(err_pulse), .step(step), .tc_in(tc_in),
        .chan_mode(chan_mode), .chan_mask(chan_mask), .chan_req(chan_req),
        .ctl_cmd(ctl_cmd)
    );

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        bus_addr = 4'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a, int exp, string tag);
        bus_addr = 4'(a); bus_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse_step(int ch);
        step[ch] = 1'b1; @(negedge clk); step = '0;
    endtask

    task automatic pulse_tc(int ch);
        tc_in[ch] = 1'b1; @(negedge clk); tc_in = '0;
    endtask

    // Monitor: note each read strobe, compare on the following falling edge
    always @(posedge clk) pend <= bus_rd;
    always @(negedge clk) begin
        if (pend) begin
            if (exp_q.size() == 0) chk("scoreboard underflow", 1, 0);
            else chk(tag_q.pop_front(), int'(bus_rdata), exp_q.pop_front());
        end
    end

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 reset mask", int'(chan_mask), 'hF);
        chk("R6 reset req", int'(chan_req), 0);
        chk("R10 reset cmd", int'(ctl_cmd), 0);
        rd(8, 'h00, "R12 reset status");

        // R1/R2: channel 1 address, channel 0 address, channel 1 count
        wr(2, 'h34); wr(2, 'h12);
        wr(0, 'hCD); wr(0, 'hAB);
        rd(2, 'h34, "R2 lo byte"); rd(2, 'h12, "R2 hi byte");
        rd(0, 'hCD, "R1 ch0 lo"); rd(0, 'hAB, "R1 ch0 hi");
        rd(3, 'h00, "R1 ch1 count lo"); rd(3, 'h00, "R1 ch1 count hi");

        // R3: high-only write keeps the low byte
        rd(2, 'h34, "R3 pre lo");
        wr(2, 'h42);
        rd(2, 'h34, "R3 kept lo"); rd(2, 'h42, "R3 new hi");
        wr(2, 'h99);
        rd(2, 'h42, "R4 lo write no reload");
        rd(2, 'h34, "R4 lo write no reload lo");
        wr(2, 'h55);
        rd(2, 'h99, "R3 merged lo"); rd(2, 'h55, "R3 merged hi");

        // R4/R5/R8: progress, decrement, count readback
        pulse_step(1); pulse_step(1); pulse_step(1);
        rd(2, 'h9C, "R5 addr inc lo"); rd(2, 'h55, "R5 addr inc hi");
        wr(11, 'h21);
        chk("R8 mode ch1", int'(chan_mode[15:8]), 'h21);
        chk("R8 mode ch0", int'(chan_mode[7:0]), 0);
        rd(2, 'h96, "R5 addr dec lo"); rd(2, 'h55, "R5 addr dec hi");
        wr(3, 'h10); wr(3, 'h00);
        rd(2, 'h99, "R4 reload lo"); rd(2, 'h55, "R4 reload hi");
        pulse_step(1); pulse_step(1);
        rd(3, 'h0E, "R5 count lo"); rd(3, 'h00, "R5 count hi");
        rd(2, 'h97, "R5 dec after count"); rd(2, 'h55, "R5 dec hi");

        // R6/R12: request and terminal count
        wr(9, 'h06);
        chk("R6 req set", int'(chan_req), 'h4);
        rd(8, 'h40, "R12 status req");
        pulse_tc(2);
        rd(8, 'h44, "R12 status tc"); rd(8, 'h40, "R12 tc cleared by read");
        pulse_tc(2);
        wr(9, 'h02);
        chk("R6 req clear", int'(chan_req), 0);
        rd(8, 'h00, "R6 tc cleared by request port");

        // R7: masking
        wr(14, 0);   chk("R7 clear all", int'(chan_mask), 0);
        wr(10, 'h05); chk("R7 single set", int'(chan_mask), 'h2);
        wr(10, 'h07); chk("R7 single set 3", int'(chan_mask), 'hA);
        wr(10, 'h01); chk("R7 single clear", int'(chan_mask), 'h8);
        wr(15, 'h05); chk("R7 load all", int'(chan_mask), 'h5);
        rd(9, 'h05, "R7 mask read");

        // R10/R11: command filter and error pulse
        wr(8, 'h04);
        chk("R10 cmd accepted", int'(ctl_cmd), 'h04);
        chk("R11 no err", int'(err_pulse), 0);
        wr(8, 'h01);
        chk("R11 err pulse", int'(err_pulse), 1);
        chk("R10 cmd kept", int'(ctl_cmd), 'h04);
        @(negedge clk);
        chk("R11 err one cycle", int'(err_pulse), 0);
        rd(12, 'h00, "R11 write-only read");
        chk("R11 err on wo read", int'(err_pulse), 1);
        @(negedge clk);
        chk("R11 err drop", int'(err_pulse), 0);

        // R9: pointer clear and master reset
        wr(0, 'h11);
        wr(12, 0);
        rd(0, 'hCD, "R9 ptr cleared"); rd(0, 'hAB, "R9 ptr hi");
        wr(9, 'h05); wr(14, 0); wr(2, 'hEE);
        wr(13, 0);
        chk("R9 mask set", int'(chan_mask), 'hF);
        chk("R9 req cleared", int'(chan_req), 0);
        chk("R9 cmd cleared", int'(ctl_cmd), 0);
        chk("R9 mode kept", int'(chan_mode[15:8]), 'h21);
        rd(2, 'h97, "R9 ptr reset lo"); rd(2, 'h55, "R9 ptr reset hi");

        repeat (2) @(negedge clk);
        chk("scoreboard drained", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule